// File: doc/BRIEF.md
# Banked Bus Decoder and Speed Arbiter

This block sits beside a 16-bit-capable CPU that drives a 24-bit address made of an 8-bit bank and a 16-bit offset. For each access it picks one of three targets: the fast main-memory bus, the slow peripheral bus, or the video-memory bus. It also drives a CPU clock-enable. The enable holds the CPU for as many fast clocks as the chosen target needs. The slow peripheral bus runs at one eighth of the fast clock. A free-running phase counter marks the single fast clock in each slow period where a peripheral access may complete. Video memory is shared with a display fetch engine, and a fetch request always wins the video bus.

A small control register selects how the low banks are mapped. In native mapping, the peripheral bank and the two video banks are reached only at their own bank numbers. Shadow bits can overlay them onto the low banks. The peripheral overlay covers a fixed 2 KB window in bank 00h, and also the 16 KB cartridge window when a cartridge is fitted. The video overlay covers banks 00h and 01h. A compatibility bit turns on both overlays at once.

Top module: `bank_route_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, the control register is zero. With a zero register, bank 00h offset D000h resolves to the fast bus even when a cartridge is present.
- R2: Any offset in bank C0h resolves to the slow peripheral bus in every mapping.
- R3: Any offset in banks D0h and D1h resolves to the video bus in every mapping.
- R4: With the peripheral overlay on (control bit 0), bank 00h offsets D000h–D7FFh resolve to the peripheral bus. Offset D800h stays on the fast bus.
- R5: Bank 00h offsets 8000h–BFFFh resolve to the peripheral bus only when the peripheral overlay is on and cart_present is high. Otherwise they go to the fast bus.
- R6: With the video overlay on (control bit 1), banks 00h and 01h resolve to the video bus. Where the peripheral overlay also claims an offset, the peripheral bus wins.
- R7: Control bit 2 (compatibility) turns on both overlays, whatever bits 0 and 1 hold.
- R8: A phase counter clears at reset and advances once per clock, modulo 8. A peripheral-bus access sees cpu_ce high only in the clock where the phase is 7.
- R9: A video-bus access sees cpu_ce low in every clock where fetch_req is high, and high otherwise.
- R10: Fast-bus accesses, including banks other than 00h, 01h, C0h, D0h and D1h, see cpu_ce high. With no access request, all three selects are low and cpu_ce is high.
- R11: The control register loads ctrl_wdata on a clock edge where ctrl_we is high, and holds its value otherwise.
- R12: wr_stb is high exactly when a write request (rnw low) completes, that is, when cpu_req is high and cpu_ce is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | CPU access in progress |
| cpu_bank | input | 8 | Bank byte of the address |
| cpu_addr | input | 16 | Offset within the bank |
| cpu_rnw | input | 1 | High for read, low for write |
| cart_present | input | 1 | Cartridge fitted |
| ctrl_we | input | 1 | Control register write enable |
| ctrl_wdata | input | 3 | bit0 peripheral overlay, bit1 video overlay, bit2 compatibility |
| fetch_req | input | 1 | Display fetch engine claims the video bus |
| sel_fast | output | 1 | Access routed to fast bus |
| sel_io | output | 1 | Access routed to slow peripheral bus |
| sel_vid | output | 1 | Access routed to video bus |
| cpu_ce | output | 1 | CPU clock-enable |
| wr_stb | output | 1 | Write completes this clock |

## Verification
On every cycle the assertions check three things: at most one select is high, the phase counter advances by exactly one modulo the ratio, and a completing peripheral access is always followed by phase zero. They also check that a video access never completes during a fetch and that the control register changes only on a write. Only the bench scenarios can show the address map itself. That covers the edges of each window, the cartridge dependence, the priority of the peripheral window over the video overlay, and the compatibility override. These are compared against a behavioural model on every clock.

// File: rtl/bar_pkg.sv
package bar_pkg;
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_FAST = 2'd1,
      TGT_IO   = 2'd2,
      TGT_VID  = 2'd3
   } bar_tgt_e;

   typedef struct packed {
      logic compat;
      logic vid_sh;
      logic io_sh;
   } bar_ctrl_t;
endpackage

// File: rtl/bar_ctrl_reg.sv
module bar_ctrl_reg
   import bar_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      we,
   input  logic [2:0] wdata,
   output bar_ctrl_t ctrl,
   output logic      io_sh_eff,
   output logic      vid_sh_eff
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl <= '0;
      else if (we) ctrl <= bar_ctrl_t'(wdata);
   end

   assign io_sh_eff  = ctrl.io_sh  | ctrl.compat;
   assign vid_sh_eff = ctrl.vid_sh | ctrl.compat;

   a_r11_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(ctrl));
   a_r11_load : assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (ctrl == bar_ctrl_t'($past(wdata))));
endmodule

// File: rtl/bar_phase.sv
module bar_phase #(
   parameter int RATIO = 8,
   localparam int PH_W = (RATIO > 1) ? $clog2(RATIO) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [PH_W-1:0] phase,
   output logic            last
);
   localparam logic [PH_W-1:0] LAST_PH = PH_W'(RATIO - 1);

   if (RATIO < 2) begin : g_bad_ratio
      $error("bar_phase: RATIO must be at least 2");
   end

   if ((RATIO & (RATIO - 1)) == 0) begin : g_pow2
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) phase <= '0;
         else        phase <= phase + 1'b1;
      end
   end else begin : g_mod
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               phase <= '0;
         else if (phase == LAST_PH) phase <= '0;
         else                      phase <= phase + 1'b1;
      end
   end

   assign last = (phase == LAST_PH);

   a_r8_phase_step : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (phase == (($past(phase) == LAST_PH) ? '0 : $past(phase) + 1'b1)));
endmodule

// File: rtl/bar_decode.sv
module bar_decode
   import bar_pkg::*;
#(
   parameter int              BANK_W    = 8,
   parameter int              ADDR_W    = 16,
   parameter logic [BANK_W-1:0] IO_BANK  = 8'hC0,
   parameter logic [BANK_W-1:0] VID_BANK = 8'hD0,
   parameter int              VID_BANKS = 2,
   parameter logic [ADDR_W-1:0] IO_LO   = 16'hD000,
   parameter logic [ADDR_W-1:0] IO_HI   = 16'hD7FF,
   parameter logic [ADDR_W-1:0] CART_LO = 16'h8000,
   parameter logic [ADDR_W-1:0] CART_HI = 16'hBFFF
) (
   input  logic              req,
   input  logic [BANK_W-1:0] bank,
   input  logic [ADDR_W-1:0] addr,
   input  logic              cart,
   input  logic              io_sh,
   input  logic              vid_sh,
   output bar_tgt_e          tgt
);
   if (VID_BANKS < 1 || VID_BANKS > 16) begin : g_bad_vb
      $error("bar_decode: VID_BANKS out of range");
   end
   if (IO_LO > IO_HI || CART_LO > CART_HI) begin : g_bad_win
      $error("bar_decode: window bounds reversed");
   end

   logic [VID_BANKS-1:0] vid_home_hit;
   logic [VID_BANKS-1:0] vid_low_hit;

   for (genvar i = 0; i < VID_BANKS; i++) begin : g_vb
      assign vid_home_hit[i] = (bank == VID_BANK + BANK_W'(i));
      assign vid_low_hit[i]  = (bank == BANK_W'(i));
   end

   logic low0, io_win, cart_win, io_hit, vid_hit;

   always_comb begin
      low0     = (bank == '0);
      io_win   = (addr >= IO_LO) && (addr <= IO_HI);
      cart_win = (addr >= CART_LO) && (addr <= CART_HI) && cart;
      io_hit   = (bank == IO_BANK) || (io_sh && low0 && (io_win || cart_win));
      vid_hit  = (|vid_home_hit) || (vid_sh && (|vid_low_hit));
      if (!req)         tgt = TGT_NONE;
      else if (io_hit)  tgt = TGT_IO;
      else if (vid_hit) tgt = TGT_VID;
      else              tgt = TGT_FAST;
   end
endmodule

// File: rtl/bank_route_arbiter.sv
module bank_route_arbiter
   import bar_pkg::*;
#(
   parameter int BANK_W    = 8,
   parameter int ADDR_W    = 16,
   parameter int RATIO     = 8,
   parameter int VID_BANKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic [BANK_W-1:0] cpu_bank,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rnw,
   input  logic              cart_present,
   input  logic              ctrl_we,
   input  logic [2:0]        ctrl_wdata,
   input  logic              fetch_req,
   output logic              sel_fast,
   output logic              sel_io,
   output logic              sel_vid,
   output logic              cpu_ce,
   output logic              wr_stb
);
   localparam int PH_W = (RATIO > 1) ? $clog2(RATIO) : 1;

   bar_ctrl_t        ctrl;
   logic             io_sh, vid_sh;
   logic [PH_W-1:0]  phase;
   logic             ph_last;
   bar_tgt_e         tgt;

   bar_ctrl_reg u_ctrl (
      .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata),
      .ctrl(ctrl), .io_sh_eff(io_sh), .vid_sh_eff(vid_sh)
   );

   bar_phase #(.RATIO(RATIO)) u_phase (
      .clk(clk), .rst_n(rst_n), .phase(phase), .last(ph_last)
   );

   bar_decode #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .VID_BANKS(VID_BANKS)) u_dec (
      .req(cpu_req), .bank(cpu_bank), .addr(cpu_addr), .cart(cart_present),
      .io_sh(io_sh), .vid_sh(vid_sh), .tgt(tgt)
   );

   always_comb begin
      sel_fast = (tgt == TGT_FAST);
      sel_io   = (tgt == TGT_IO);
      sel_vid  = (tgt == TGT_VID);
      unique case (tgt)
         TGT_IO:  cpu_ce = ph_last;
         TGT_VID: cpu_ce = !fetch_req;
         default: cpu_ce = 1'b1;
      endcase
      wr_stb = cpu_req && !cpu_rnw && cpu_ce;
   end

   a_r10_one_target : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_fast, sel_io, sel_vid}));
   a_r10_req_target : assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req |-> ($countones({sel_fast, sel_io, sel_vid}) == 1));
   a_r8_io_wrap : assert property (@(posedge clk) disable iff (!rst_n)
      (sel_io && cpu_ce) |=> (phase == '0));
   a_r9_fetch_stall : assert property (@(posedge clk) disable iff (!rst_n)
      (sel_vid && fetch_req) |-> !cpu_ce);
   a_r12_no_read_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rnw |-> !wr_stb);
endmodule

// File: tb/bank_route_arbiter_tb_top.sv
module bank_route_arbiter_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic [7:0]  cpu_bank = '0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_rnw = 1'b1;
   logic        cart_present = 1'b0;
   logic        ctrl_we = 1'b0;
   logic [2:0]  ctrl_wdata = '0;
   logic        fetch_req = 1'b0;
   logic        sel_fast, sel_io, sel_vid, cpu_ce, wr_stb;

   int vectors = 0;
   int fails = 0;
   int m_phase = 0;
   logic [2:0] m_ctrl = '0;
   logic done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bank_route_arbiter dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_bank(cpu_bank),
      .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw), .cart_present(cart_present),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .fetch_req(fetch_req),
      .sel_fast(sel_fast), .sel_io(sel_io), .sel_vid(sel_vid),
      .cpu_ce(cpu_ce), .wr_stb(wr_stb)
   );

   // behavioural reference state
   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase <= 0;
         m_ctrl  <= '0;
      end else begin
         m_phase <= (m_phase + 1) % 8;
         if (ctrl_we) m_ctrl <= ctrl_wdata;
      end
   end

   task automatic check(input string tag);
      bit ios, vds, io, vd;
      logic [4:0] exp, got;
      ios = m_ctrl[0] || m_ctrl[2];
      vds = m_ctrl[1] || m_ctrl[2];
      io = (cpu_bank == 8'hC0) ||
           (ios && cpu_bank == 8'h00 &&
            ((cpu_addr >= 16'hD000 && cpu_addr <= 16'hD7FF) ||
             (cart_present && cpu_addr >= 16'h8000 && cpu_addr <= 16'hBFFF)));
      vd = (cpu_bank == 8'hD0 || cpu_bank == 8'hD1) ||
           (vds && (cpu_bank == 8'h00 || cpu_bank == 8'h01));
      exp = '0;
      exp[1] = 1'b1;
      if (cpu_req) begin
         if (io)      begin exp[3] = 1'b1; exp[1] = (m_phase == 7); end
         else if (vd) begin exp[2] = 1'b1; exp[1] = !fetch_req; end
         else         exp[4] = 1'b1;
      end
      exp[0] = cpu_req && !cpu_rnw && exp[1];
      got = {sel_fast, sel_io, sel_vid, cpu_ce, wr_stb};
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: {fast,io,vid,ce,wr} got %b expected %b (bank %h addr %h)",
                  tag, got, exp, cpu_bank, cpu_addr);
      end
   endtask

   task automatic apply(input string tag, input bit req, input logic [7:0] bk,
                        input logic [15:0] ad, input bit rnw, input bit cart,
                        input bit fr);
      @(negedge clk);
      cpu_req = req; cpu_bank = bk; cpu_addr = ad; cpu_rnw = rnw;
      cart_present = cart; fetch_req = fr; ctrl_we = 1'b0;
      #1 check(tag);
   endtask

   task automatic wr_ctrl(input logic [2:0] v);
      @(negedge clk);
      cpu_req = 1'b0; ctrl_we = 1'b1; ctrl_wdata = v;
      #1 check("R11");
      @(negedge clk);
      ctrl_we = 1'b0;
      #1 check("R11");
   endtask

   initial begin
      // R1 reset state
      repeat (2) apply("R1", 1'b1, 8'h00, 16'hD000, 1'b1, 1'b1, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      apply("R1", 1'b1, 8'h00, 16'hD000, 1'b1, 1'b1, 1'b0);
      apply("R1", 1'b1, 8'h00, 16'h9000, 1'b1, 1'b1, 1'b0);
      // R2 / R8 held peripheral access over two slow periods
      for (int i = 0; i < 17; i++) apply("R8", 1'b1, 8'hC0, 16'h1234, 1'b1, 1'b0, 1'b0);
      apply("R2", 1'b1, 8'hC0, 16'hFFFF, 1'b0, 1'b0, 1'b0);
      // R3 / R9 video banks
      apply("R3", 1'b1, 8'hD1, 16'hFFFF, 1'b1, 1'b0, 1'b0);
      apply("R9", 1'b1, 8'hD0, 16'h0000, 1'b0, 1'b0, 1'b1);
      apply("R9", 1'b1, 8'hD0, 16'h0000, 1'b0, 1'b0, 1'b1);
      apply("R9", 1'b1, 8'hD0, 16'h0000, 1'b0, 1'b0, 1'b0);
      // R4 / R5 peripheral overlay
      wr_ctrl(3'b001);
      apply("R4", 1'b1, 8'h00, 16'hD000, 1'b1, 1'b0, 1'b0);
      apply("R4", 1'b1, 8'h00, 16'hD7FF, 1'b1, 1'b0, 1'b0);
      apply("R4", 1'b1, 8'h00, 16'hD800, 1'b1, 1'b0, 1'b0);
      apply("R5", 1'b1, 8'h00, 16'h8000, 1'b1, 1'b0, 1'b0);
      apply("R5", 1'b1, 8'h00, 16'h8000, 1'b1, 1'b1, 1'b0);
      apply("R5", 1'b1, 8'h00, 16'hBFFF, 1'b1, 1'b1, 1'b0);
      apply("R5", 1'b1, 8'h00, 16'hC000, 1'b1, 1'b1, 1'b0);
      apply("R5", 1'b1, 8'h00, 16'h7FFF, 1'b1, 1'b1, 1'b0);
      apply("R4", 1'b1, 8'h01, 16'hD000, 1'b1, 1'b0, 1'b0);
      // R6 video overlay and priority
      wr_ctrl(3'b010);
      apply("R6", 1'b1, 8'h01, 16'h0000, 1'b1, 1'b0, 1'b0);
      apply("R6", 1'b1, 8'h00, 16'hD000, 1'b1, 1'b1, 1'b1);
      wr_ctrl(3'b011);
      apply("R6", 1'b1, 8'h00, 16'hD000, 1'b1, 1'b0, 1'b0);
      apply("R6", 1'b1, 8'h00, 16'hA000, 1'b1, 1'b1, 1'b0);
      apply("R6", 1'b1, 8'h00, 16'hA000, 1'b1, 1'b0, 1'b0);
      // R7 compatibility override
      wr_ctrl(3'b100);
      apply("R7", 1'b1, 8'h00, 16'hD400, 1'b1, 1'b0, 1'b0);
      apply("R7", 1'b1, 8'h01, 16'h4000, 1'b1, 1'b0, 1'b1);
      apply("R7", 1'b1, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b0);
      // R10 other banks and idle
      apply("R10", 1'b1, 8'h02, 16'hD000, 1'b0, 1'b1, 1'b1);
      apply("R10", 1'b1, 8'hC1, 16'h0000, 1'b1, 1'b0, 1'b0);
      apply("R10", 1'b1, 8'hD2, 16'h0000, 1'b1, 1'b0, 1'b0);
      apply("R10", 1'b0, 8'hC0, 16'h0000, 1'b0, 1'b0, 1'b1);
      // R12 write strobe
      apply("R12", 1'b1, 8'h7F, 16'h0001, 1'b0, 1'b0, 1'b0);
      apply("R12", 1'b1, 8'h7F, 16'h0001, 1'b1, 1'b0, 1'b0);
      wr_ctrl(3'b000);
      apply("R1", 1'b1, 8'h00, 16'hD000, 1'b1, 1'b1, 1'b0);
      // mixed traffic
      for (int i = 0; i < 400; i++) begin
         logic [7:0] bk;
         case ($urandom_range(0, 5))
            0: bk = 8'h00; 1: bk = 8'h01; 2: bk = 8'hC0;
            3: bk = 8'hD0; 4: bk = 8'hD1; default: bk = 8'($urandom);
         endcase
         if ($urandom_range(0, 15) == 0) begin
            @(negedge clk);
            cpu_req = 1'b0; ctrl_we = 1'b1; ctrl_wdata = 3'($urandom);
            #1 check("R11");
         end
         apply("RND", 1'($urandom), bk, 16'($urandom), 1'($urandom),
               1'($urandom), 1'($urandom));
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule